// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block sits beside the receive and transmit FIFOs of a UART and decides which of eight interrupt causes the host is told about. Each cycle it gates the raw causes with their enable bits, picks the most urgent one by a fixed ranking, and publishes an identification byte together with an active-low interrupt request. The host reads the byte to learn what to service next.

Two pieces of state that feed the ranking live inside the block. A stale-data timer counts character-time strobes since the last received stop bit or FIFO read, and fires once enough character times have passed while data waits below the trigger level. An error tally counts the receive-FIFO entries that carry a parity, framing or break flag. It drives a summary error flag that stays up until every errored entry has left the FIFO. A transmit-space latch remembers that the transmit FIFO has fallen to its threshold until the host acknowledges it.

Top module: `uart_irq_ident`

## Requirements
- R1: The identification byte has bit 0 at 0 when an interrupt is pending and at 1 when none is pending. Bits 7:6 both copy `fifo_en_i`. After reset with `fifo_en_i` low it reads 0x01.
- R2: Bits 5:0 report the highest-ranked pending enabled cause. From first to last the causes and codes are: line error 000110, receive timeout 001100, receive data 000100, transmit space 000010, modem change 000000, input-pin change 110000, Xoff or special character 010000, RTS/CTS change 100000.
- R3: The receive-data cause is `rx_at_trig_i` when `fifo_en_i` is high and `rx_nonempty_i` when it is low. It shares enable bit `ien_i[0]` with the timeout cause.
- R4: With `fifo_en_i` high, the timeout cause is raised once TO_CHARS (default 4) `char_tick_i` strobes have arrived since the timer last restarted, while `rx_nonempty_i` is high and `rx_at_trig_i` is low.
- R5: The timer restarts on `stop_mid_i`, on `rx_pop_i`, and whenever the receive FIFO is empty.
- R6: The error tally rises on a push with `rx_push_err_i` and falls on a pop with `rx_pop_err_i`. `rx_fifo_clr_i` zeroes it. `err_sum_o` is high while the tally is nonzero and is the line-error cause, enabled by `ien_i[2]`.
- R7: `head_err_o` equals `head_err_i` while `rx_nonempty_i` is high and is zero while the FIFO is empty.
- R8: The transmit-space latch sets only on a rising edge of `tx_below_i` while `ien_i[1]` is high. It clears on `tx_write_i`, on `iir_rd_i` while the byte reports code 000010, or while `ien_i[1]` is low. Turning the enable back on with `tx_below_i` already high raises nothing.
- R9: `irq_n_o` is low exactly when an enabled cause is pending. A cause whose enable is low changes neither output. The enables are: `ien_i[3]` modem, `ien_i[4]` input pins, `ien_i[5]` Xoff, `ien_i[6]` RTS/CTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | FIFO mode enabled |
| ien_i | input | 7 | Interrupt enable bits |
| rx_nonempty_i | input | 1 | Receive FIFO holds data |
| rx_at_trig_i | input | 1 | Receive FIFO level at or above trigger |
| rx_push_i | input | 1 | Character pushed into receive FIFO |
| rx_push_err_i | input | 1 | Pushed character carries an error |
| rx_pop_i | input | 1 | Host read of receive FIFO |
| rx_pop_err_i | input | 1 | Popped character carried an error |
| rx_fifo_clr_i | input | 1 | Receive FIFO reset |
| head_err_i | input | 3 | Error flags of the head character |
| stop_mid_i | input | 1 | Strobe at middle of received stop bit |
| char_tick_i | input | 1 | One-character-time strobe |
| tx_below_i | input | 1 | Transmit FIFO at or below threshold |
| tx_write_i | input | 1 | Host write to transmit FIFO |
| modem_chg_i | input | 1 | Modem input change flag |
| pin_chg_i | input | 1 | General input pin change flag |
| xoff_i | input | 1 | Xoff or special character flag |
| flow_chg_i | input | 1 | RTS/CTS change flag |
| iir_rd_i | input | 1 | Host read of identification byte |
| iir_o | output | 8 | Identification byte |
| err_sum_o | output | 1 | Errored entries remain in receive FIFO |
| head_err_o | output | 3 | Head character error flags shown to host |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
A wrong error tally shows as `err_sum_o` and the line-error code staying up after the last errored pop, or dropping while one entry remains. This is visible within two cycles of the pop. A timer that counts wrong moves the 001100 code one character strobe early or late, and a missed restart leaves it up after a stop bit or a read. A transmit latch that rearms on the enable, or ignores an acknowledge, shows 000010 where the bench expects 0xC1. Every state error surfaces at `iir_o` within two clocks of the stimulus that exposes it.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   localparam int unsigned NSRC = 8;
   localparam int unsigned IEN_W = 7;

   typedef enum logic [2:0] {
      SRC_LINE = 3'd0,
      SRC_TOUT = 3'd1,
      SRC_RXD  = 3'd2,
      SRC_TXS  = 3'd3,
      SRC_MDM  = 3'd4,
      SRC_PIN  = 3'd5,
      SRC_XOFF = 3'd6,
      SRC_FLOW = 3'd7
   } src_e;

   localparam logic [5:0] CODE_NONE = 6'b000001;
   localparam logic [5:0] CODE_TXS  = 6'b000010;

   // rank 0 is the most urgent
   function automatic logic [5:0] src_code(input int unsigned rank);
      logic [5:0] c;
      case (rank)
         0: c = 6'b000110;
         1: c = 6'b001100;
         2: c = 6'b000100;
         3: c = 6'b000010;
         4: c = 6'b000000;
         5: c = 6'b110000;
         6: c = 6'b010000;
         default: c = 6'b100000;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/uirq_rx_timeout.sv
module uirq_rx_timeout #(
   parameter int unsigned TO_CHARS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_nonempty_i,
   input  logic below_trig_i,
   input  logic stop_mid_i,
   input  logic rx_pop_i,
   input  logic char_tick_i,
   output logic fire_o
);
   localparam int unsigned CW = $clog2(TO_CHARS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(TO_CHARS);

   initial begin
      if (TO_CHARS < 1) $error("TO_CHARS must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          restart;

   assign restart = stop_mid_i | rx_pop_i | ~rx_nonempty_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (char_tick_i && cnt_q != LIMIT) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign fire_o = (cnt_q == LIMIT) & rx_nonempty_i & below_trig_i;

   AST_TO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      stop_mid_i |=> !fire_o); // R5
endmodule

// File: rtl/uirq_err_tally.sv
module uirq_err_tally #(
   parameter int unsigned FIFO_DEPTH = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_err_i,
   input  logic pop_err_i,
   input  logic clr_i,
   output logic err_sum_o
);
   localparam int unsigned TW = $clog2(FIFO_DEPTH + 1);
   localparam logic [TW-1:0] TMAX = TW'(FIFO_DEPTH);

   initial begin
      if (FIFO_DEPTH < 2) $error("FIFO_DEPTH must be at least 2");
   end

   logic [TW-1:0] tally_q;
   logic          up, down;

   assign up   = push_err_i & ~pop_err_i & (tally_q != TMAX);
   assign down = pop_err_i & ~push_err_i & (tally_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tally_q <= '0;
      end else if (clr_i) begin
         tally_q <= '0;
      end else if (up) begin
         tally_q <= tally_q + 1'b1;
      end else if (down) begin
         tally_q <= tally_q - 1'b1;
      end
   end

   assign err_sum_o = (tally_q != '0);

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !err_sum_o); // R6
   AST_ERR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (push_err_i && !pop_err_i && !clr_i) |=> err_sum_o); // R6
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio #(
   parameter int unsigned N = uirq_pkg::NSRC
) (
   input  logic [N-1:0] req_i,
   output logic [5:0]   code_o,
   output logic         pend_o
);
   initial begin
      if (N != uirq_pkg::NSRC) $error("prio width must match source count");
   end

   always_comb begin
      code_o = uirq_pkg::CODE_NONE;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) code_o = uirq_pkg::src_code(i);
      end
      pend_o = |req_i;
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
   parameter int unsigned FIFO_DEPTH = 64,
   parameter int unsigned TO_CHARS   = 4,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fifo_en_i,
   input  logic [6:0] ien_i,
   input  logic       rx_nonempty_i,
   input  logic       rx_at_trig_i,
   input  logic       rx_push_i,
   input  logic       rx_push_err_i,
   input  logic       rx_pop_i,
   input  logic       rx_pop_err_i,
   input  logic       rx_fifo_clr_i,
   input  logic [2:0] head_err_i,
   input  logic       stop_mid_i,
   input  logic       char_tick_i,
   input  logic       tx_below_i,
   input  logic       tx_write_i,
   input  logic       modem_chg_i,
   input  logic       pin_chg_i,
   input  logic       xoff_i,
   input  logic       flow_chg_i,
   input  logic       iir_rd_i,
   output logic [7:0] iir_o,
   output logic       err_sum_o,
   output logic [2:0] head_err_o,
   output logic       irq_n_o
);
   import uirq_pkg::*;

   logic            to_fire, err_sum;
   logic            thr_q, below_q, rpt_thr;
   logic [NSRC-1:0] raw, en_sel, req;
   logic [5:0]      code;
   logic            pend;
   logic [7:0]      iir_n;

   uirq_rx_timeout #(.TO_CHARS(TO_CHARS)) u_tout (
      .clk, .rst_n,
      .rx_nonempty_i,
      .below_trig_i (fifo_en_i & ~rx_at_trig_i),
      .stop_mid_i,
      .rx_pop_i,
      .char_tick_i,
      .fire_o       (to_fire)
   );

   uirq_err_tally #(.FIFO_DEPTH(FIFO_DEPTH)) u_tally (
      .clk, .rst_n,
      .push_err_i (rx_push_i & rx_push_err_i),
      .pop_err_i  (rx_pop_i & rx_pop_err_i),
      .clr_i      (rx_fifo_clr_i),
      .err_sum_o  (err_sum)
   );

   // transmit-space latch: edge-set, acknowledge-cleared
   assign rpt_thr = (iir_o[5:0] == CODE_TXS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         below_q <= 1'b1;
         thr_q   <= 1'b0;
      end else begin
         below_q <= tx_below_i;
         if (!ien_i[1] || tx_write_i || (iir_rd_i && rpt_thr)) begin
            thr_q <= 1'b0;
         end else if (tx_below_i && !below_q) begin
            thr_q <= 1'b1;
         end
      end
   end

   always_comb begin
      raw           = '0;
      raw[SRC_LINE] = err_sum;
      raw[SRC_TOUT] = to_fire;
      raw[SRC_RXD]  = fifo_en_i ? rx_at_trig_i : rx_nonempty_i;
      raw[SRC_TXS]  = thr_q;
      raw[SRC_MDM]  = modem_chg_i;
      raw[SRC_PIN]  = pin_chg_i;
      raw[SRC_XOFF] = xoff_i;
      raw[SRC_FLOW] = flow_chg_i;
      en_sel           = '0;
      en_sel[SRC_LINE] = ien_i[2];
      en_sel[SRC_TOUT] = ien_i[0];
      en_sel[SRC_RXD]  = ien_i[0];
      en_sel[SRC_TXS]  = 1'b1;
      en_sel[SRC_MDM]  = ien_i[3];
      en_sel[SRC_PIN]  = ien_i[4];
      en_sel[SRC_XOFF] = ien_i[5];
      en_sel[SRC_FLOW] = ien_i[6];
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_gate
      assign req[g] = raw[g] & en_sel[g];
   end

   uirq_prio #(.N(NSRC)) u_prio (
      .req_i  (req),
      .code_o (code),
      .pend_o (pend)
   );

   assign iir_n = {{2{fifo_en_i}}, code[5:1], ~pend};

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            iir_o   <= 8'h01;
            irq_n_o <= 1'b1;
         end else begin
            iir_o   <= iir_n;
            irq_n_o <= ~pend;
         end
      end

      AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
         (err_sum && ien_i[2]) |=> (iir_o[5:0] == 6'b000110)); // R2
   end else begin : g_comb_out
      assign iir_o   = iir_n;
      assign irq_n_o = ~pend;
   end

   assign err_sum_o  = err_sum;
   assign head_err_o = rx_nonempty_i ? head_err_i : 3'b000;

   AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n_o |-> (iir_o[5:0] == 6'b000001)); // R9
   AST_THR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ien_i[1] |=> !thr_q); // R8
endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
   localparam time TCLK = 10ns;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fifo_en = 0, rx_ne = 0, at_trig = 0, push = 0, push_err = 0;
   logic pop = 0, pop_err = 0, fclr = 0, stop_mid = 0, ctick = 0;
   logic tx_below = 0, tx_wr = 0, modem = 0, pin = 0, xoff = 0, flow = 0, iird = 0;
   logic [6:0] ien = '0;
   logic [2:0] head_in = '0;
   logic [7:0] iir;
   logic       err_sum, irq_n;
   logic [2:0] head_out;

   int total = 0, bad = 0;
   bit done = 0;

   typedef struct {
      logic [7:0] iir;
      logic       irq_n;
      logic       err;
      logic [2:0] head;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #(TCLK/2) clk = ~clk;

   uart_irq_ident dut_i (
      .clk, .rst_n, .fifo_en_i(fifo_en), .ien_i(ien),
      .rx_nonempty_i(rx_ne), .rx_at_trig_i(at_trig),
      .rx_push_i(push), .rx_push_err_i(push_err),
      .rx_pop_i(pop), .rx_pop_err_i(pop_err), .rx_fifo_clr_i(fclr),
      .head_err_i(head_in), .stop_mid_i(stop_mid), .char_tick_i(ctick),
      .tx_below_i(tx_below), .tx_write_i(tx_wr),
      .modem_chg_i(modem), .pin_chg_i(pin), .xoff_i(xoff), .flow_chg_i(flow),
      .iir_rd_i(iird), .iir_o(iir), .err_sum_o(err_sum),
      .head_err_o(head_out), .irq_n_o(irq_n)
   );

   // monitor: pops expectations and compares against the live outputs
   initial begin
      forever begin
         exp_t e;
         wait (sb_q.size() != 0);
         e = sb_q.pop_front();
         total++;
         if (iir !== e.iir || irq_n !== e.irq_n || err_sum !== e.err || head_out !== e.head) begin
            bad++;
            $display("FAIL %s: iir=%h irq_n=%b err=%b head=%b expected iir=%h irq_n=%b err=%b head=%b",
                     e.tag, iir, irq_n, err_sum, head_out, e.iir, e.irq_n, e.err, e.head);
         end
      end
   end

   task automatic settle();
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic expect_now(input logic [7:0] ei, input logic eq, input logic ee,
                             input logic [2:0] eh, input string tag);
      exp_t e;
      settle();
      e.iir = ei; e.irq_n = eq; e.err = ee; e.head = eh; e.tag = tag;
      sb_q.push_back(e);
      #1;
   endtask

   task automatic edge_at();
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         edge_at(); ctick = 1;
         edge_at(); ctick = 0;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      edge_at(); rst_n = 1;
      expect_now(8'h01, 1, 0, 3'b000, "R1 reset value");

      // receive data, FIFO mode off then on
      edge_at(); ien = 7'h01; rx_ne = 1;
      expect_now(8'h04, 0, 0, 3'b000, "R3 data without FIFO mode");
      edge_at(); fifo_en = 1;
      expect_now(8'hC1, 1, 0, 3'b000, "R3 FIFO mode below trigger, R1 bits 7:6");
      edge_at(); at_trig = 1;
      expect_now(8'hC4, 0, 0, 3'b000, "R3 FIFO mode at trigger");

      // error tally and line error priority
      edge_at(); ien = 7'h05; push = 1; push_err = 1;
      edge_at(); push = 0; push_err = 0;
      expect_now(8'hC6, 0, 1, 3'b000, "R2 R6 line error above data");
      edge_at(); push = 1; push_err = 1;
      edge_at(); push = 0; push_err = 0; pop = 1; pop_err = 1;
      edge_at(); pop = 0; pop_err = 0;
      expect_now(8'hC6, 0, 1, 3'b000, "R6 one errored entry remains");
      edge_at(); pop = 1; pop_err = 1;
      edge_at(); pop = 0; pop_err = 0;
      expect_now(8'hC4, 0, 0, 3'b000, "R6 last errored entry popped");
      edge_at(); push = 1; push_err = 1;
      edge_at(); push = 0; push_err = 0;
      expect_now(8'hC6, 0, 1, 3'b000, "R6 set again");
      edge_at(); fclr = 1;
      edge_at(); fclr = 0;
      expect_now(8'hC4, 0, 0, 3'b000, "R6 FIFO reset clears tally");

      // head error visibility
      edge_at(); head_in = 3'b101;
      expect_now(8'hC4, 0, 0, 3'b101, "R7 head flags with data");
      edge_at(); rx_ne = 0; at_trig = 0;
      expect_now(8'hC1, 1, 0, 3'b000, "R7 head flags hidden when empty");
      edge_at(); head_in = 3'b000;

      // stale-data timeout
      edge_at(); ien = 7'h01; rx_ne = 1; stop_mid = 1;
      edge_at(); stop_mid = 0;
      ticks(3);
      expect_now(8'hC1, 1, 0, 3'b000, "R4 three character times: no timeout");
      ticks(1);
      expect_now(8'hCC, 0, 0, 3'b000, "R4 fourth character time raises timeout");
      edge_at(); pop = 1;
      edge_at(); pop = 0;
      expect_now(8'hC1, 1, 0, 3'b000, "R5 read restarts timer");
      ticks(4);
      expect_now(8'hCC, 0, 0, 3'b000, "R4 timeout after restart");
      edge_at(); stop_mid = 1;
      edge_at(); stop_mid = 0;
      expect_now(8'hC1, 1, 0, 3'b000, "R5 stop bit restarts timer");
      edge_at(); rx_ne = 0;

      // transmit space latch
      edge_at(); ien = 7'h02; tx_below = 1;
      expect_now(8'hC2, 0, 0, 3'b000, "R8 rising threshold sets");
      edge_at(); iird = 1;
      edge_at(); iird = 0;
      expect_now(8'hC1, 1, 0, 3'b000, "R8 ident read acknowledges");
      edge_at(); ien = 7'h00;
      settle();
      edge_at(); ien = 7'h02;
      expect_now(8'hC1, 1, 0, 3'b000, "R8 re-enable does not rearm");
      edge_at(); tx_below = 0;
      settle();
      edge_at(); tx_below = 1;
      expect_now(8'hC2, 0, 0, 3'b000, "R8 second rising edge sets");
      edge_at(); tx_wr = 1;
      edge_at(); tx_wr = 0;
      expect_now(8'hC1, 1, 0, 3'b000, "R8 transmit write clears");

      // low-ranked causes
      edge_at(); ien = 7'h78; modem = 1; pin = 1; xoff = 1; flow = 1;
      expect_now(8'hC0, 0, 0, 3'b000, "R2 modem change ranks first");
      edge_at(); modem = 0;
      expect_now(8'hF0, 0, 0, 3'b000, "R2 pin change next");
      edge_at(); pin = 0;
      expect_now(8'hD0, 0, 0, 3'b000, "R2 Xoff next");
      edge_at(); xoff = 0;
      expect_now(8'hE0, 0, 0, 3'b000, "R2 RTS/CTS change last");
      edge_at(); flow = 0;
      expect_now(8'hC1, 1, 0, 3'b000, "R9 nothing pending");

      // disabled causes have no effect
      edge_at(); ien = 7'h00; modem = 1; xoff = 1; pin = 1; flow = 1;
      expect_now(8'hC1, 1, 0, 3'b000, "R9 disabled causes ignored");
      edge_at(); fifo_en = 0;
      expect_now(8'h01, 1, 0, 3'b000, "R1 bits 7:6 follow FIFO enable");

      wait (sb_q.size() == 0);
      #1;
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule